// File: doc/BRIEF.md
# Bidirectional GPIO Port

This block is one register-mapped port of general-purpose pins. Each pin has three control bits: a direction bit, an output bit and a pin-input address bit. The direction bit decides whether the pin drives its pad. The output bit does two jobs. On an output pin it is the level driven onto the pad. On an input pin it switches on a weak pull-up. Writing ones to the pin-input address flips the matching output bits, whatever the direction setting. Reading that same address returns the pad level after a synchronizer.

Software reaches the port through a simple strobe bus. There is one shared write-data bus with a write strobe for each of the three addresses. There is one shared read-data bus with a read strobe for the direction register, the output register and the synchronized pad value. Two control inputs are common to every port in the chip. A global pull-up kill forces every pull-up off. A sleep input closes the path from the pad into the synchronizer. The pad cell, the pull-up resistor and any alternate pin function sit outside this block.

Top module: `gpio_port`

## Requirements
- R1: `pad_oe[i]` equals direction bit i. A 1 makes pin i an output and a 0 makes it an input. `wr_dir` loads the direction register from `wdata` at the next rising edge.
- R2: `pad_do[i]` equals output bit i while pin i is an output, and it is 0 while pin i is an input. `wr_out` loads the output register from `wdata` at the next rising edge.
- R3: `pad_pu[i]` is 1 only when pin i is an input, output bit i is 1 and `pullup_off` is 0. It is therefore 0 whenever output bit i is 0 or pin i is an output.
- R4: While `pullup_off` is 1, every bit of `pad_pu` is 0. The registers are left unchanged, so the pull-ups come back when `pullup_off` returns to 0.
- R5: `wr_pin` inverts each output bit whose `wdata` bit is 1, whatever the direction bits hold. Output bits whose `wdata` bit is 0 keep their value, and the direction register is not touched.
- R6: If `wr_out` and `wr_pin` are high in the same cycle, the output register takes `wdata` and the toggle is dropped.
- R7: `rst` is active high and asynchronous. It clears the direction register, the output register and the synchronizer at once, without waiting for a clock edge. While it is high, all pins are inputs with no pull-up.
- R8: Suppose `pad_in` changes before rising edge k while `sleep` is 0. With `rd_pin` high, `rdata` shows the new value after edge k+1 and still shows the old value between edges k and k+1.
- R9: While `sleep` is 1, the synchronizer takes in 0 in place of `pad_in`. Two edges after `sleep` rises, an `rd_pin` read returns 0.
- R10: `rdata` returns the direction register when `rd_dir` is high. Otherwise it returns the output register when `rd_out` is high, and otherwise the synchronized pad value when `rd_pin` is high. With no read strobe high it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the other ports |
| rst | input | 1 | Asynchronous active-high reset |
| sleep | input | 1 | Sleep control; gates the pad input path |
| pullup_off | input | 1 | Global kill for every pull-up |
| wr_dir | input | 1 | Write strobe for the direction register |
| wr_out | input | 1 | Write strobe for the output register |
| wr_pin | input | 1 | Write strobe for the pin-input address (toggle) |
| wdata | input | WIDTH | Shared write data |
| rd_dir | input | 1 | Read strobe for the direction register |
| rd_out | input | 1 | Read strobe for the output register |
| rd_pin | input | 1 | Read strobe for the synchronized pad value |
| rdata | output | WIDTH | Shared read data |
| pad_in | input | WIDTH | Pad input level of each pin |
| pad_oe | output | WIDTH | Drive enable of each pin |
| pad_do | output | WIDTH | Drive value of each pin |
| pad_pu | output | WIDTH | Pull-up enable of each pin |

## Verification
The bench builds the port with its defaults: WIDTH of 8 and SYNC_STAGES of 2. At eight bits, each register write can use a pattern in which the two nibbles, and the inputs and outputs, hold different values. A lost toggle, a swapped pull-up term or a drive leaking onto an input pin then shows up as a specific wrong bit. With two stages the latency is short enough to check the value at each edge: the old pad level after the first edge and the new one after the second. That gives an exact check of the R8 latency and of how sleep clears the path.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Per-pin pad control bundle
    typedef struct packed {
        logic oe;
        logic dout;
        logic pu;
    } pin_drive_t;

    // Read source selector
    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_DIR,
        RSEL_OUT,
        RSEL_PIN
    } rd_sel_e;

    // Pad control of one pin from its register bits
    function automatic pin_drive_t pin_drive(input logic dir_b,
                                             input logic out_b,
                                             input logic pu_kill);
        pin_drive_t d;
        d.oe   = dir_b;
        d.dout = dir_b & out_b;
        d.pu   = ~dir_b & out_b & ~pu_kill;
        return d;
    endfunction

    // Priority decode of the read strobes
    function automatic rd_sel_e rd_decode(input logic r_dir,
                                          input logic r_out,
                                          input logic r_pin);
        if (r_dir)      return RSEL_DIR;
        else if (r_out) return RSEL_OUT;
        else if (r_pin) return RSEL_PIN;
        else            return RSEL_NONE;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_dir,
    input  logic             wr_out,
    input  logic             wr_pin,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q
);

    logic [WIDTH-1:0] out_next;

    // A direct write wins over a toggle in the same cycle
    always_comb begin
        if (wr_out)
            out_next = wdata;
        else if (wr_pin)
            out_next = out_q ^ wdata;
        else
            out_next = out_q;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (wr_dir)
                dir_q <= wdata;
            out_q <= out_next;
        end
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] head,
    output logic [WIDTH-1:0] tail
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= sleep ? '0 : pad_in;
            for (int i = 1; i < STAGES; i++)
                stg[i] <= stg[i-1];
        end
    end

    assign head = stg[0];
    assign tail = stg[LAST];

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             pullup_off,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_do,
    output logic [WIDTH-1:0] pad_pu
);

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        pin_drive_t drv;
        assign drv       = pin_drive(dir_q[p], out_q[p], pullup_off);
        assign pad_oe[p] = drv.oe;
        assign pad_do[p] = drv.dout;
        assign pad_pu[p] = drv.pu;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep,
    input  logic             pullup_off,
    input  logic             wr_dir,
    input  logic             wr_out,
    input  logic             wr_pin,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_dir,
    input  logic             rd_out,
    input  logic             rd_pin,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_do,
    output logic [WIDTH-1:0] pad_pu
);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] sync_head;
    logic [WIDTH-1:0] sync_tail;
    rd_sel_e          rd_sel;

    gpio_regs #(.WIDTH(WIDTH)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_dir (wr_dir),
        .wr_out (wr_out),
        .wr_pin (wr_pin),
        .wdata  (wdata),
        .dir_q  (dir_q),
        .out_q  (out_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .sleep  (sleep),
        .pad_in (pad_in),
        .head   (sync_head),
        .tail   (sync_tail)
    );

    gpio_pad_ctl #(.WIDTH(WIDTH)) i_pad (
        .pullup_off (pullup_off),
        .dir_q      (dir_q),
        .out_q      (out_q),
        .pad_oe     (pad_oe),
        .pad_do     (pad_do),
        .pad_pu     (pad_pu)
    );

    assign rd_sel = rd_decode(rd_dir, rd_out, rd_pin);

    always_comb begin
        case (rd_sel)
            RSEL_DIR: rdata = dir_q;
            RSEL_OUT: rdata = out_q;
            RSEL_PIN: rdata = sync_tail;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sleep,
    input logic             pullup_off,
    input logic             wr_out,
    input logic             wr_pin,
    input logic [WIDTH-1:0] wdata,
    input logic             rd_dir,
    input logic             rd_out,
    input logic             rd_pin,
    input logic [WIDTH-1:0] rdata,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_do,
    input logic [WIDTH-1:0] pad_pu,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] out_q,
    input logic [WIDTH-1:0] sync_head,
    input logic [WIDTH-1:0] sync_tail
);

    p_oe_dir_r1: assert property (@(posedge clk) disable iff (rst)
        pad_oe == dir_q);

    p_no_drive_input_r2: assert property (@(posedge clk) disable iff (rst)
        (pad_do & ~pad_oe) == '0);

    p_pu_excl_r3: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0);

    p_pu_kill_r4: assert property (@(posedge clk) disable iff (rst)
        pullup_off |-> pad_pu == '0);

    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_pin && !wr_out) |=> out_q == $past(out_q ^ wdata));

    p_write_wins_r6: assert property (@(posedge clk) disable iff (rst)
        wr_out |=> out_q == $past(wdata));

    p_reset_state_r7: assert property (@(posedge clk)
        rst |-> (pad_oe == '0 && pad_pu == '0 && out_q == '0));

    p_sync_shift_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sync_tail == $past(sync_head));

    p_sleep_gate_r9: assert property (@(posedge clk) disable iff (rst)
        sleep |=> sync_head == '0);

    p_rd_dir_r10: assert property (@(posedge clk) disable iff (rst)
        rd_dir |-> rdata == dir_q);

    p_rd_out_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_out && !rd_dir) |-> rdata == out_q);

    p_rd_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!rd_dir && !rd_out && !rd_pin) |-> rdata == '0);

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep      (sleep),
    .pullup_off (pullup_off),
    .wr_out     (wr_out),
    .wr_pin     (wr_pin),
    .wdata      (wdata),
    .rd_dir     (rd_dir),
    .rd_out     (rd_out),
    .rd_pin     (rd_pin),
    .rdata      (rdata),
    .pad_oe     (pad_oe),
    .pad_do     (pad_do),
    .pad_pu     (pad_pu),
    .dir_q      (dir_q),
    .out_q      (out_q),
    .sync_head  (sync_head),
    .sync_tail  (sync_tail)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;

    localparam int W       = 8;
    localparam int CLK_PER = 10;
    localparam int NVEC    = 8;

    typedef struct packed {
        logic         wd;
        logic         wo;
        logic         wp;
        logic [W-1:0] data;
        logic [W-1:0] oe;
        logic [W-1:0] dout;
        logic [W-1:0] pu;
    } vec_t;

    // Cumulative register steps from reset; expected pad controls after each
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 8'h0F, 8'h0F, 8'h00, 8'h00},
        '{1'b0, 1'b1, 1'b0, 8'h3C, 8'h0F, 8'h0C, 8'h30},
        '{1'b0, 1'b0, 1'b1, 8'h81, 8'h0F, 8'h0D, 8'hB0},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'h0F, 8'h0D, 8'hB0},
        '{1'b1, 1'b0, 1'b0, 8'hF0, 8'hF0, 8'hB0, 8'h0D},
        '{1'b0, 1'b1, 1'b1, 8'h5A, 8'hF0, 8'h50, 8'h0A},
        '{1'b0, 1'b0, 1'b1, 8'hFF, 8'hF0, 8'hA0, 8'h05},
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'hA5}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sleep = 1'b0;
    logic         pullup_off = 1'b0;
    logic         wr_dir = 1'b0;
    logic         wr_out = 1'b0;
    logic         wr_pin = 1'b0;
    logic [W-1:0] wdata = '0;
    logic         rd_dir = 1'b0;
    logic         rd_out = 1'b0;
    logic         rd_pin = 1'b0;
    logic [W-1:0] rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_do;
    logic [W-1:0] pad_pu;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    gpio_port #(.WIDTH(W), .SYNC_STAGES(2)) i_gpio_port (
        .clk        (clk),
        .rst        (rst),
        .sleep      (sleep),
        .pullup_off (pullup_off),
        .wr_dir     (wr_dir),
        .wr_out     (wr_out),
        .wr_pin     (wr_pin),
        .wdata      (wdata),
        .rd_dir     (rd_dir),
        .rd_out     (rd_out),
        .rd_pin     (rd_pin),
        .rdata      (rdata),
        .pad_in     (pad_in),
        .pad_oe     (pad_oe),
        .pad_do     (pad_do),
        .pad_pu     (pad_pu)
    );

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_reg(input int which, output logic [W-1:0] val);
        rd_dir = (which == 0);
        rd_out = (which == 1);
        rd_pin = (which == 2);
        #1;
        val = rdata;
        rd_dir = 1'b0;
        rd_out = 1'b0;
        rd_pin = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] v;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R7 reset state
        check("R7 oe in reset", pad_oe, '0);
        check("R7 pu in reset", pad_pu, '0);
        rst = 1'b0;
        @(negedge clk);
        read_reg(2, v);
        check("R10 pin read after reset", v, '0);
        read_reg(3, v);
        check("R10 no strobe reads zero", v, '0);

        // Vector walk: R1 R2 R3 R5 R6
        for (int k = 0; k < NVEC; k++) begin
            wr_dir = VECS[k].wd;
            wr_out = VECS[k].wo;
            wr_pin = VECS[k].wp;
            wdata  = VECS[k].data;
            @(posedge clk);
            @(negedge clk);
            wr_dir = 1'b0;
            wr_out = 1'b0;
            wr_pin = 1'b0;
            check($sformatf("R1 oe step %0d", k), pad_oe, VECS[k].oe);
            check($sformatf("R2 R5 R6 do step %0d", k), pad_do, VECS[k].dout);
            check($sformatf("R3 R5 R6 pu step %0d", k), pad_pu, VECS[k].pu);
        end

        // R10 register reads and priority
        read_reg(1, v);
        check("R10 out read", v, 8'hA5);
        read_reg(0, v);
        check("R10 dir read", v, 8'h00);
        rd_dir = 1'b1; rd_out = 1'b1; rd_pin = 1'b1;
        #1;
        check("R10 dir has priority", rdata, 8'h00);
        rd_dir = 1'b0;
        #1;
        check("R10 out over pin", rdata, 8'hA5);
        rd_out = 1'b0; rd_pin = 1'b0;

        // R5 toggle leaves direction alone
        wr_pin = 1'b1; wdata = 8'h0F;
        @(posedge clk); @(negedge clk);
        wr_pin = 1'b0;
        read_reg(0, v);
        check("R5 toggle keeps dir", v, 8'h00);
        read_reg(1, v);
        check("R5 toggle out", v, 8'hAA);
        check("R3 pu after toggle", pad_pu, 8'hAA);

        // R4 global pull-up kill
        pullup_off = 1'b1;
        #1;
        check("R4 pu forced off", pad_pu, 8'h00);
        pullup_off = 1'b0;
        #1;
        check("R4 pu restored", pad_pu, 8'hAA);

        // R8 two-stage synchronizer latency
        pad_in = 8'hC3;
        @(posedge clk); @(negedge clk);
        read_reg(2, v);
        check("R8 pin after one edge", v, 8'h00);
        @(posedge clk); @(negedge clk);
        read_reg(2, v);
        check("R8 pin after two edges", v, 8'hC3);

        // R9 sleep gates the input path
        sleep = 1'b1;
        pad_in = 8'h5A;
        repeat (2) @(posedge clk);
        @(negedge clk);
        read_reg(2, v);
        check("R9 pin during sleep", v, 8'h00);
        sleep = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        read_reg(2, v);
        check("R9 pin after wake", v, 8'h5A);

        // R7 asynchronous reset between edges
        wr_dir = 1'b1; wdata = 8'hFF;
        @(posedge clk); @(negedge clk);
        wr_dir = 1'b0;
        check("R1 all outputs", pad_oe, 8'hFF);
        #1 rst = 1'b1;
        #1;
        check("R7 async oe clear", pad_oe, 8'h00);
        check("R7 async do clear", pad_do, 8'h00);
        read_reg(1, v);
        check("R7 async out clear", v, 8'h00);
        read_reg(2, v);
        check("R7 async sync clear", v, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule